// File: doc/BRIEF.md
# Gather Packet Launch Controller

This block sits between one processing element of a mesh accelerator and the local injection port of that node's router. The processing element hands over one finished result word. The block keeps the word and offers it to the router's merge unit, so that the word can ride on a gather packet that is already travelling along the row toward the global buffer. If the merge unit takes the word, it returns an acknowledge and the block goes back to idle.

When no passing packet takes the word, the block builds a four-flit gather packet of its own. The word is the first payload entry of that packet, and the packet is addressed to the buffer column at the right edge of the node's own row. Three events start this fallback: a programmable wait interval expires, the merge unit returns a negative acknowledge, or a passing gather header reports that it has no free slot. A node in column zero has no upstream neighbour, so it skips the wait and launches at once.

The word input and the flit output are valid/ready streams. A word moves only in a cycle where `pe_valid` and `pe_ready` are both high. A flit moves only in a cycle where `inj_valid` and `inj_ready` are both high. While `inj_ready` is low, the offered flit stays unchanged.

Top module: `gather_launch_ctrl`

## Requirements
- R1: `pe_ready` is high only when no word is held. A word is taken on `pe_valid && pe_ready`. While `pe_ready` is low, `pe_valid` and `pe_data` have no effect on the held word.
- R2: In a column other than zero, a taken word is offered: `offer_valid` rises in the cycle after capture, with `offer_data` equal to the word.
- R3: `up_ack` while offering clears the word. In the next cycle `pe_ready` is high and no flit is injected.
- R4: With no ack, nack or full header, `offer_valid` stays high for exactly `cfg_wait` cycles (0 is treated as 1), and `inj_valid` rises in the following cycle.
- R5: `up_nack` (with no `up_ack`) while offering starts injection in the next cycle.
- R6: `hdr_valid` with `hdr_space == 0` while offering starts injection in the next cycle. A header with nonzero space has no effect.
- R7: When `node_col == 0`, a taken word is never offered. `inj_valid` rises in the cycle after capture.
- R8: A packet is `PKT_FLITS` (4) flits in this order: head, body, body, tail. The flit kind is held in bits [FLIT_W-1:FLIT_W-2]: head 2'b01, body 2'b10, tail 2'b11.
- R9: The head flit carries the packet type gather (2'b11) in [FLIT_W-3:FLIT_W-4]. The low bits hold, upward from bit 0: destination column `BUF_COL` (COL_W bits), destination row `node_row` (ROW_W bits), source column `node_col`, source row `node_row`, and the free slot count `PKT_FLITS-2` (SPACE_W bits). All other bits are zero.
- R10: The first flit after the head carries the word in [PAYLOAD_W-1:0]. Later flits carry zero payload.
- R11: `inj_flit` and `inj_valid` hold steady while `inj_ready` is low. Flits go back to back. `pe_ready` is high in the cycle after the tail is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pe_valid | input | 1 | Result word valid |
| pe_ready | output | 1 | Block can take a word |
| pe_data | input | PAYLOAD_W | Result word |
| offer_valid | output | 1 | Word offered to the merge unit |
| offer_data | output | PAYLOAD_W | Offered word |
| up_ack | input | 1 | Merge unit took the word |
| up_nack | input | 1 | Merge unit refused the word |
| hdr_valid | input | 1 | A passing gather header is observed |
| hdr_space | input | SPACE_W | Free slot count of that header |
| cfg_wait | input | WAIT_W | Piggyback wait interval in cycles |
| node_row | input | ROW_W | Row of this node |
| node_col | input | COL_W | Column of this node |
| inj_valid | output | 1 | Flit valid to the injection port |
| inj_ready | input | 1 | Injection port accepts the flit |
| inj_flit | output | PAYLOAD_W+2 | Flit |

## Verification
Some rules hold in every cycle, and the bound checker asserts them. Idle excludes both offering and injecting. An ack, a nack or a zero-space header has its fixed next-cycle effect. The offer never lasts longer than the configured interval, and expiry leads straight into injection. A stalled flit stays stable, every packet opens with a head flit, and column zero never offers. Other points can only be shown by the bench's scenarios: the exact field contents of each flit, the payload placement, the precise length of the wait for several interval settings (including zero), that a nonzero-space header or a word presented while busy changes nothing, and the return to ready after the tail.

// File: rtl/gather_launch_pkg.sv
package gather_launch_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_SEND = 2'd2
  } gl_state_e;

  localparam logic [1:0] KIND_HEAD    = 2'b01;
  localparam logic [1:0] KIND_BODY    = 2'b10;
  localparam logic [1:0] KIND_TAIL    = 2'b11;
  localparam logic [1:0] PTYPE_GATHER = 2'b11;

endpackage

// File: rtl/gl_wait_timer.sv
// Counts the cycles a word has been offered; flags the last allowed cycle.
module gl_wait_timer #(
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [WAIT_W-1:0] cfg_wait,
  output logic              expired
);
  logic [WAIT_W-1:0] cnt_q;
  logic [WAIT_W:0]   eff_wait;

  // A zero interval still gives the merge unit one cycle.
  assign eff_wait = (cfg_wait == '0) ? (WAIT_W+1)'(1) : {1'b0, cfg_wait};
  assign expired  = run && (({1'b0, cnt_q} + (WAIT_W+1)'(1)) >= eff_wait);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (!run) cnt_q <= '0;
    else           cnt_q <= cnt_q + WAIT_W'(1);
  end
endmodule

// File: rtl/gl_flit_seq.sv
// Emits one self-started gather packet while send_en is high.
module gl_flit_seq
  import gather_launch_pkg::*;
#(
  parameter int PAYLOAD_W = 32,
  parameter int ROW_W     = 3,
  parameter int COL_W     = 3,
  parameter int SPACE_W   = 3,
  parameter int PKT_FLITS = 4,
  parameter int BUF_COL   = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 send_en,
  input  logic [PAYLOAD_W-1:0] payload,
  input  logic [ROW_W-1:0]     node_row,
  input  logic [COL_W-1:0]     node_col,
  input  logic                 inj_ready,
  output logic                 inj_valid,
  output logic [PAYLOAD_W+1:0] inj_flit,
  output logic                 done
);
  localparam int FLIT_W  = PAYLOAD_W + 2;
  localparam int IDX_W   = (PKT_FLITS > 2) ? $clog2(PKT_FLITS) : 1;
  localparam int DR_LSB  = COL_W;
  localparam int SC_LSB  = COL_W + ROW_W;
  localparam int SR_LSB  = 2 * COL_W + ROW_W;
  localparam int SP_LSB  = 2 * COL_W + 2 * ROW_W;
  localparam logic [IDX_W-1:0]   LAST_IDX = IDX_W'(PKT_FLITS - 1);
  localparam logic [COL_W-1:0]   DST_COL  = COL_W'(BUF_COL);
  localparam logic [SPACE_W-1:0] FREE_CNT = SPACE_W'(PKT_FLITS - 2);

  logic [IDX_W-1:0] idx_q;
  logic             fire;

  assign inj_valid = send_en;
  assign fire      = inj_valid && inj_ready;
  assign done      = fire && (idx_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n)    idx_q <= '0;
    else if (done) idx_q <= '0;
    else if (fire) idx_q <= idx_q + IDX_W'(1);
  end

  always_comb begin
    inj_flit = '0;
    if (idx_q == '0) begin
      inj_flit[FLIT_W-1 -: 2]     = KIND_HEAD;
      inj_flit[FLIT_W-3 -: 2]     = PTYPE_GATHER;
      inj_flit[0 +: COL_W]        = DST_COL;
      inj_flit[DR_LSB +: ROW_W]   = node_row;
      inj_flit[SC_LSB +: COL_W]   = node_col;
      inj_flit[SR_LSB +: ROW_W]   = node_row;
      inj_flit[SP_LSB +: SPACE_W] = FREE_CNT;
    end else begin
      inj_flit[FLIT_W-1 -: 2] = (idx_q == LAST_IDX) ? KIND_TAIL : KIND_BODY;
      if (idx_q == IDX_W'(1)) inj_flit[PAYLOAD_W-1:0] = payload;
    end
  end
endmodule

// File: rtl/gl_ctrl.sv
// Holds the word and decides between piggyback and self-launch.
module gl_ctrl
  import gather_launch_pkg::*;
#(
  parameter int PAYLOAD_W = 32,
  parameter int SPACE_W   = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pe_valid,
  input  logic [PAYLOAD_W-1:0] pe_data,
  output logic                 pe_ready,
  input  logic                 leftmost,
  input  logic                 up_ack,
  input  logic                 up_nack,
  input  logic                 hdr_valid,
  input  logic [SPACE_W-1:0]   hdr_space,
  input  logic                 timer_expired,
  input  logic                 send_done,
  output logic                 holding,
  output logic                 send_en,
  output logic [PAYLOAD_W-1:0] held_word
);
  gl_state_e state_q;
  logic      hdr_full;
  logic      give_up;

  assign hdr_full = hdr_valid && (hdr_space == '0);
  assign give_up  = up_nack || hdr_full || timer_expired;
  assign pe_ready = (state_q == ST_IDLE);
  assign holding  = (state_q == ST_HOLD);
  assign send_en  = (state_q == ST_SEND);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      held_word <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (pe_valid) begin
          held_word <= pe_data;
          state_q   <= leftmost ? ST_SEND : ST_HOLD;
        end
        ST_HOLD: begin
          if (up_ack)       state_q <= ST_IDLE;
          else if (give_up) state_q <= ST_SEND;
        end
        ST_SEND: if (send_done) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gather_launch_ctrl.sv
module gather_launch_ctrl #(
  parameter int PAYLOAD_W = 32,
  parameter int ROW_W     = 3,
  parameter int COL_W     = 3,
  parameter int SPACE_W   = 3,
  parameter int WAIT_W    = 8,
  parameter int PKT_FLITS = 4,
  parameter int BUF_COL   = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pe_valid,
  output logic                 pe_ready,
  input  logic [PAYLOAD_W-1:0] pe_data,
  output logic                 offer_valid,
  output logic [PAYLOAD_W-1:0] offer_data,
  input  logic                 up_ack,
  input  logic                 up_nack,
  input  logic                 hdr_valid,
  input  logic [SPACE_W-1:0]   hdr_space,
  input  logic [WAIT_W-1:0]    cfg_wait,
  input  logic [ROW_W-1:0]     node_row,
  input  logic [COL_W-1:0]     node_col,
  output logic                 inj_valid,
  input  logic                 inj_ready,
  output logic [PAYLOAD_W+1:0] inj_flit
);
  logic                 holding;
  logic                 send_en;
  logic                 timer_expired;
  logic                 send_done;
  logic                 leftmost;
  logic [PAYLOAD_W-1:0] held_word;

  assign leftmost    = (node_col == '0);
  assign offer_valid = holding;
  assign offer_data  = held_word;

  gl_ctrl #(.PAYLOAD_W(PAYLOAD_W), .SPACE_W(SPACE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .pe_valid(pe_valid), .pe_data(pe_data), .pe_ready(pe_ready),
    .leftmost(leftmost), .up_ack(up_ack), .up_nack(up_nack),
    .hdr_valid(hdr_valid), .hdr_space(hdr_space),
    .timer_expired(timer_expired), .send_done(send_done),
    .holding(holding), .send_en(send_en), .held_word(held_word)
  );

  gl_wait_timer #(.WAIT_W(WAIT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(holding),
    .cfg_wait(cfg_wait), .expired(timer_expired)
  );

  gl_flit_seq #(
    .PAYLOAD_W(PAYLOAD_W), .ROW_W(ROW_W), .COL_W(COL_W),
    .SPACE_W(SPACE_W), .PKT_FLITS(PKT_FLITS), .BUF_COL(BUF_COL)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .send_en(send_en), .payload(held_word),
    .node_row(node_row), .node_col(node_col), .inj_ready(inj_ready),
    .inj_valid(inj_valid), .inj_flit(inj_flit), .done(send_done)
  );
endmodule

// File: rtl/gather_launch_chk.sv
module gather_launch_chk #(
  parameter int PAYLOAD_W = 32,
  parameter int COL_W     = 3,
  parameter int SPACE_W   = 3,
  parameter int WAIT_W    = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 pe_ready,
  input logic                 offer_valid,
  input logic [PAYLOAD_W-1:0] offer_data,
  input logic                 up_ack,
  input logic                 up_nack,
  input logic                 hdr_valid,
  input logic [SPACE_W-1:0]   hdr_space,
  input logic [WAIT_W-1:0]    cfg_wait,
  input logic [COL_W-1:0]     node_col,
  input logic                 inj_valid,
  input logic                 inj_ready,
  input logic [PAYLOAD_W+1:0] inj_flit
);
  localparam int FLIT_W = PAYLOAD_W + 2;

  logic [WAIT_W:0] offer_run;
  logic [WAIT_W:0] eff_wait;

  assign eff_wait = (cfg_wait == '0) ? (WAIT_W+1)'(1) : {1'b0, cfg_wait};

  always_ff @(posedge clk) begin
    if (!rst_n)            offer_run <= '0;
    else if (!offer_valid) offer_run <= '0;
    else if (offer_run != '1) offer_run <= offer_run + (WAIT_W+1)'(1);
  end

  p_idle_exclusive_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pe_ready |-> (!offer_valid && !inj_valid));
  p_offer_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (offer_valid && $past(offer_valid)) |-> $stable(offer_data));
  p_ack_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (offer_valid && up_ack) |=> (pe_ready && !inj_valid));
  p_wait_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    offer_valid |-> (offer_run < eff_wait));
  p_wait_expire_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (offer_valid && !up_ack && (offer_run + (WAIT_W+1)'(1) == eff_wait)) |=> inj_valid);
  p_nack_launch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (offer_valid && !up_ack && up_nack) |=> inj_valid);
  p_full_launch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (offer_valid && !up_ack && hdr_valid && hdr_space == '0) |=> inj_valid);
  p_edge_no_offer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (node_col == '0) |-> !offer_valid);
  p_head_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inj_valid) |-> (inj_flit[FLIT_W-1 -: 2] == 2'b01));
  p_stall_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (inj_valid && !inj_ready) |=> (inj_valid && $stable(inj_flit)));
endmodule

bind gather_launch_ctrl gather_launch_chk #(
  .PAYLOAD_W(PAYLOAD_W), .COL_W(COL_W), .SPACE_W(SPACE_W), .WAIT_W(WAIT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pe_ready(pe_ready), .offer_valid(offer_valid),
  .offer_data(offer_data), .up_ack(up_ack), .up_nack(up_nack),
  .hdr_valid(hdr_valid), .hdr_space(hdr_space), .cfg_wait(cfg_wait),
  .node_col(node_col), .inj_valid(inj_valid), .inj_ready(inj_ready),
  .inj_flit(inj_flit)
);

// File: tb/gather_launch_ctrl_tb.sv
module gather_launch_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pe_valid = 1'b0;
  logic        pe_ready;
  logic [31:0] pe_data = '0;
  logic        offer_valid;
  logic [31:0] offer_data;
  logic        up_ack = 1'b0;
  logic        up_nack = 1'b0;
  logic        hdr_valid = 1'b0;
  logic [2:0]  hdr_space = '0;
  logic [7:0]  cfg_wait = 8'd5;
  logic [2:0]  node_row = 3'd5;
  logic [2:0]  node_col = 3'd3;
  logic        inj_valid;
  logic        inj_ready = 1'b0;
  logic [33:0] inj_flit;

  int n_chk = 0;
  int n_err = 0;
  bit done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gather_launch_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .pe_valid(pe_valid), .pe_ready(pe_ready),
    .pe_data(pe_data), .offer_valid(offer_valid), .offer_data(offer_data),
    .up_ack(up_ack), .up_nack(up_nack), .hdr_valid(hdr_valid),
    .hdr_space(hdr_space), .cfg_wait(cfg_wait), .node_row(node_row),
    .node_col(node_col), .inj_valid(inj_valid), .inj_ready(inj_ready),
    .inj_flit(inj_flit)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_word(input logic [31:0] d);
    @(negedge clk);
    check("R1 ready before word", pe_ready, 1);
    pe_valid = 1'b1;
    pe_data  = d;
    @(negedge clk);
    pe_valid = 1'b0;
  endtask

  // Accepts one packet with ready held high and checks every field.
  task automatic collect(input logic [31:0] d);
    inj_ready = 1'b1;
    for (int i = 0; i < 4; i++) begin
      check("R11 back-to-back valid", inj_valid, 1);
      if (i == 0) begin
        check("R8 head kind", inj_flit[33:32], 2'b01);
        check("R9 packet type", inj_flit[31:30], 2'b11);
        check("R9 free slots", inj_flit[14:12], 2);
        check("R9 source row", inj_flit[11:9], node_row);
        check("R9 source col", inj_flit[8:6], node_col);
        check("R9 dest row", inj_flit[5:3], node_row);
        check("R9 dest col", inj_flit[2:0], 7);
        check("R9 unused bits", inj_flit[29:15], 0);
      end else begin
        check("R8 body/tail kind", inj_flit[33:32], (i == 3) ? 2'b11 : 2'b10);
        check("R10 payload", inj_flit[31:0], (i == 1) ? d : 32'd0);
      end
      @(negedge clk);
    end
    inj_ready = 1'b0;
    check("R11 ready after tail", pe_ready, 1);
    check("R11 no valid after tail", inj_valid, 0);
  endtask

  task automatic t_reset();
    check("R1 reset ready", pe_ready, 1);
    check("R2 reset no offer", offer_valid, 0);
    check("R8 reset no flit", inj_valid, 0);
  endtask

  task automatic t_timeout(input logic [7:0] w, input logic [31:0] d);
    int n;
    cfg_wait = w;
    send_word(d);
    n = 0;
    while (offer_valid && n < 50) begin
      check("R2 offer data", offer_data, d);
      check("R1 busy not ready", pe_ready, 0);
      n++;
      @(negedge clk);
    end
    check("R4 offer length", n, (w == 0) ? 1 : w);
    check("R4 launch after wait", inj_valid, 1);
    collect(d);
    cfg_wait = 8'd5;
  endtask

  task automatic t_ack(input logic [31:0] d);
    send_word(d);
    pe_valid = 1'b1;
    pe_data  = 32'hDEAD_BEEF;
    @(negedge clk);
    pe_valid = 1'b0;
    check("R1 busy word ignored", offer_data, d);
    up_ack = 1'b1;
    @(negedge clk);
    up_ack = 1'b0;
    check("R3 ready after ack", pe_ready, 1);
    check("R3 offer cleared", offer_valid, 0);
    for (int i = 0; i < 8; i++) begin
      check("R3 no injection", inj_valid, 0);
      @(negedge clk);
    end
  endtask

  task automatic t_nack(input logic [31:0] d);
    send_word(d);
    @(negedge clk);
    up_nack = 1'b1;
    @(negedge clk);
    up_nack = 1'b0;
    check("R5 launch after nack", inj_valid, 1);
    check("R5 offer dropped", offer_valid, 0);
    collect(d);
  endtask

  task automatic t_header(input logic [31:0] d);
    send_word(d);
    hdr_valid = 1'b1;
    hdr_space = 3'd2;
    @(negedge clk);
    check("R6 roomy header ignored", offer_valid, 1);
    check("R6 roomy header no flit", inj_valid, 0);
    hdr_space = 3'd0;
    @(negedge clk);
    hdr_valid = 1'b0;
    check("R6 launch on full header", inj_valid, 1);
    collect(d);
  endtask

  task automatic t_leftmost(input logic [31:0] d);
    node_col = 3'd0;
    send_word(d);
    check("R7 no offer in column zero", offer_valid, 0);
    check("R7 immediate launch", inj_valid, 1);
    collect(d);
    node_col = 3'd3;
  endtask

  task automatic t_stall(input logic [31:0] d);
    logic [33:0] first;
    node_row = 3'd2;
    send_word(d);
    up_nack = 1'b1;
    @(negedge clk);
    up_nack = 1'b0;
    first = inj_flit;
    for (int i = 0; i < 3; i++) begin
      check("R11 valid held in stall", inj_valid, 1);
      check("R11 flit held in stall", inj_flit, first);
      @(negedge clk);
    end
    collect(d);
    node_row = 3'd5;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_timeout(8'd5, 32'hA5A5_0001);
    t_timeout(8'd2, 32'h1234_5678);
    t_timeout(8'd0, 32'h0F0F_F0F0);
    t_ack(32'hCAFE_0002);
    t_nack(32'h7777_0003);
    t_header(32'h0000_0044);
    t_leftmost(32'hBEEF_0005);
    t_stall(32'h8000_0006);
    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule